// File: doc/BRIEF.md
# Staged Boot Sequencer with Retries

This block supervises the release of two chips from reset once power and clocking are good. It first lets the graphics processor out of reset and waits for that chip to report that its reset is complete. It then waits for the serial link between the chips to report the active (L0) state. Only then does it release the main processor and wait for a one-cycle power-up-cause request pulse from software.

Each of the three waits has its own timeout, counted in clock cycles. When a wait runs out, the block records a boot-class error with a code that names the stage. It drives both chips back into reset for a minimum hold time and starts again from the first stage. Five attempts are allowed in total. After the fifth failure the block stays in a boot-error state with both chips held in reset, and it keeps the code of the stage that failed last. A new power-on request restarts the whole sequence and restores the full set of attempts.

Top module: `boot_reset_seq`

## Requirements
- R1: While reset is high and just after it, `gpu_rst_n` and `cpu_rst_n` are 0, `boot_done` is 0, and `err_class`/`err_code` are 0/0x00. The class encoding is 0 none, 1 boot, 2 fatal, 3 thermal.
- R2: `gpu_rst_n` stays 0 while `pwr_ok` is low. Once `pwr_ok` is high, the first action is to raise `gpu_rst_n`, and `cpu_rst_n` stays 0 at that point.
- R3: If `gpu_rst_done` is not seen within `T_GPU` cycles of `gpu_rst_n` rising, `gpu_rst_n` falls after exactly `T_GPU` cycles and the error becomes class 1, code 0x08.
- R4: After the reset-done input is seen, the link wait lasts at most `T_LINK` cycles. If `link_active` does not arrive in that time, the error becomes class 1, code 0x09.
- R5: `cpu_rst_n` rises only after `link_active` has been seen, and never while `gpu_rst_n` is 0. If `cause_req` is not seen within `T_HS` cycles, `cpu_rst_n` falls after exactly `T_HS` cycles and the error becomes class 1, code 0x0A.
- R6: A stage input that is present in the last cycle of its window is accepted, and no error is logged for that stage.
- R7: After a failed attempt that is not the final one, both reset outputs stay 0 for exactly `HOLD_CYC` cycles. The sequence then restarts from the graphics processor stage.
- R8: There are at most five attempts. After the fifth failure both resets stay 0, `gpu_rst_n` never rises again, and the error stays at class 1 with the code of the stage that failed last.
- R9: When `cause_req` arrives within its window, `boot_done` rises with both resets at 1. It stays there, and no further timeout is applied.
- R10: `err_code` changes only when a new error is logged. A later successful attempt leaves the logged class and code unchanged.
- R11: A one-cycle `por_req` returns the sequence to its start and clears the 3-bit attempt counter. A failure after that is retried again, even after an earlier run of five failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Power and clocking for the graphics processor are good |
| por_req | input | 1 | Pulse: new power-on request, restarts the sequence |
| gpu_rst_done | input | 1 | Graphics processor reports its reset is complete |
| link_active | input | 1 | Serial link reports the active (L0) state |
| cause_req | input | 1 | Pulse: software power-up-cause handshake |
| gpu_rst_n | output | 1 | Graphics processor reset, active low |
| cpu_rst_n | output | 1 | Main processor reset, active low |
| boot_done | output | 1 | Sequence completed |
| err_class | output | 2 | Logged error class (0 none, 1 boot, 2 fatal, 3 thermal) |
| err_code | output | 8 | Logged error code |

## Verification
A stage input and its own timeout can fall in the same cycle. This happens when the awaited input arrives exactly in the last cycle of a window. The bench provokes it by counting cycles from the moment the stage's reset output changes and driving the input on cycle `T-1`. It judges the result by checking that the sequence advances, that no new error code appears, and that `boot_done` is finally reached. The opposite case, where the input is simply absent, is judged by measuring that the reset output stayed high for exactly the window length before the matching code appeared.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_BOOT    = 2'd1,
        ERR_FATAL   = 2'd2,
        ERR_THERMAL = 2'd3
    } err_class_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_GPU_WAIT,
        ST_LINK_WAIT,
        ST_HS_WAIT,
        ST_HOLD,
        ST_UP,
        ST_STUCK
    } seq_state_e;

    typedef struct packed {
        err_class_e  cls;
        logic [7:0]  code;
    } err_rec_t;

    localparam logic [7:0] CODE_GPU_RST = 8'h08;
    localparam logic [7:0] CODE_LINK    = 8'h09;
    localparam logic [7:0] CODE_HSHAKE  = 8'h0A;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [7:0] stage_code(input seq_state_e s);
        case (s)
            ST_GPU_WAIT:  return CODE_GPU_RST;
            ST_LINK_WAIT: return CODE_LINK;
            ST_HS_WAIT:   return CODE_HSHAKE;
            default:      return 8'h00;
        endcase
    endfunction

    function automatic logic gpu_released(input seq_state_e s);
        return (s == ST_GPU_WAIT) || (s == ST_LINK_WAIT) ||
               (s == ST_HS_WAIT)  || (s == ST_UP);
    endfunction

    function automatic logic cpu_released(input seq_state_e s);
        return (s == ST_HS_WAIT) || (s == ST_UP);
    endfunction

    function automatic logic is_wait(input seq_state_e s);
        return (s == ST_GPU_WAIT) || (s == ST_LINK_WAIT) || (s == ST_HS_WAIT);
    endfunction

endpackage

// File: rtl/boot_stage_timer.sv
module boot_stage_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/boot_retry_ctr.sv
module boot_retry_ctr #(
    parameter int MAX_ATTEMPTS = 5,
    parameter int ATT_W        = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bump,
    output logic             final_try
);
    localparam logic [ATT_W-1:0] LAST_IDX = ATT_W'(MAX_ATTEMPTS - 1);

    logic [ATT_W-1:0] fails_q;

    assign final_try = (fails_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fails_q <= '0;
        end else if (bump && !final_try) begin
            fails_q <= fails_q + ATT_W'(1);
        end
    end

    // R8: the failure count never passes the last permitted attempt
    assert_fail_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        fails_q <= LAST_IDX);

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
    import boot_seq_pkg::*;
#(
    parameter int T_GPU        = 4096,
    parameter int T_LINK       = 8192,
    parameter int T_HS         = 65536,
    parameter int HOLD_CYC     = 64,
    parameter int MAX_ATTEMPTS = 5,
    parameter int ATT_W        = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok,
    input  logic       por_req,
    input  logic       gpu_rst_done,
    input  logic       link_active,
    input  logic       cause_req,
    output logic       gpu_rst_n,
    output logic       cpu_rst_n,
    output logic       boot_done,
    output logic [1:0] err_class,
    output logic [7:0] err_code
);
    localparam int MAX_T = max_of(max_of(T_GPU, T_LINK), max_of(T_HS, HOLD_CYC));
    localparam int CNT_W = $clog2(MAX_T + 1);

    seq_state_e       state_q, state_d;
    err_rec_t         err_q;
    logic             expired, final_try, restart, stage_seen, timeout;
    logic [CNT_W-1:0] limit;

    always_comb begin
        case (state_q)
            ST_GPU_WAIT:  stage_seen = gpu_rst_done;
            ST_LINK_WAIT: stage_seen = link_active;
            ST_HS_WAIT:   stage_seen = cause_req;
            default:      stage_seen = 1'b0;
        endcase
    end

    always_comb begin
        case (state_q)
            ST_GPU_WAIT:  limit = CNT_W'(T_GPU);
            ST_LINK_WAIT: limit = CNT_W'(T_LINK);
            ST_HS_WAIT:   limit = CNT_W'(T_HS);
            default:      limit = CNT_W'(HOLD_CYC);
        endcase
    end

    // the awaited input wins over the window end in the same cycle
    assign timeout = is_wait(state_q) && expired && !stage_seen && !por_req;

    always_comb begin
        state_d = state_q;
        if (por_req) begin
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:       if (pwr_ok) state_d = ST_GPU_WAIT;
                ST_GPU_WAIT:  if (stage_seen) state_d = ST_LINK_WAIT;
                ST_LINK_WAIT: if (stage_seen) state_d = ST_HS_WAIT;
                ST_HS_WAIT:   if (stage_seen) state_d = ST_UP;
                ST_HOLD:      if (expired) state_d = ST_GPU_WAIT;
                default:      state_d = state_q;
            endcase
            if (timeout) state_d = final_try ? ST_STUCK : ST_HOLD;
        end
    end

    assign restart = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            err_q   <= '{cls: ERR_NONE, code: 8'h00};
        end else begin
            state_q <= state_d;
            if (timeout) begin
                err_q <= '{cls: ERR_BOOT, code: stage_code(state_q)};
            end
        end
    end

    boot_stage_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    boot_retry_ctr #(
        .MAX_ATTEMPTS (MAX_ATTEMPTS),
        .ATT_W        (ATT_W)
    ) retry_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (por_req),
        .bump      (timeout),
        .final_try (final_try)
    );

    assign gpu_rst_n = gpu_released(state_q);
    assign cpu_rst_n = cpu_released(state_q);
    assign boot_done = (state_q == ST_UP);
    assign err_class = err_q.cls;
    assign err_code  = err_q.code;

    // R2: no release while power is not good in the idle state
    assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF && !pwr_ok && !por_req) |=> !gpu_rst_n);

    // R5: main processor never out of reset while graphics processor is held
    assert_cpu_needs_gpu_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_n |-> gpu_rst_n);

    // R8: the stuck state keeps its code and keeps both chips in reset
    assert_stuck_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STUCK && !por_req) |=> (!gpu_rst_n && $stable(err_code)));

    // R9: completion is sticky and leaves both chips running
    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (boot_done && !por_req) |=> (boot_done && gpu_rst_n && cpu_rst_n));

    // R10: a new code only ever comes with the chips dropping back into reset
    assert_code_with_reset_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_code) |-> $fell(gpu_rst_n));

endmodule

// File: tb/boot_reset_seq_tb_top.sv
module boot_reset_seq_tb_top;
    import boot_seq_pkg::*;

    localparam int T_GPU    = 20;
    localparam int T_LINK   = 16;
    localparam int T_HS     = 24;
    localparam int HOLD_CYC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0, por_req = 1'b0;
    logic gpu_rst_done = 1'b0, link_active = 1'b0, cause_req = 1'b0;
    logic gpu_rst_n, cpu_rst_n, boot_done;
    logic [1:0] err_class;
    logic [7:0] err_code;

    int checks = 0;
    int errors = 0;
    logic [9:0] exp_q[$];
    logic [9:0] model = 10'h000;

    always #4 clk = ~clk;

    boot_reset_seq #(
        .T_GPU (T_GPU), .T_LINK (T_LINK), .T_HS (T_HS), .HOLD_CYC (HOLD_CYC)
    ) dut_i (
        .clk (clk), .rst (rst), .pwr_ok (pwr_ok), .por_req (por_req),
        .gpu_rst_done (gpu_rst_done), .link_active (link_active),
        .cause_req (cause_req), .gpu_rst_n (gpu_rst_n), .cpu_rst_n (cpu_rst_n),
        .boot_done (boot_done), .err_class (err_class), .err_code (err_code)
    );

    function automatic void chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endfunction

    function automatic void push_exp(input logic [7:0] code);
        logic [9:0] rec;
        rec = {ERR_BOOT, code};
        if (rec != model) begin
            exp_q.push_back(rec);
            model = rec;
        end
    endfunction

    // monitor: every change of the logged error is compared with the queue head
    initial begin
        logic [9:0] prev;
        logic [9:0] want;
        prev = 10'h000;
        forever begin
            @(negedge clk);
            if (!rst && {err_class, err_code} != prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected error change", {err_class, err_code}, prev);
                end else begin
                    want = exp_q.pop_front();
                    chk({err_class, err_code} == want, "R10 logged error", {err_class, err_code}, want);
                end
                prev = {err_class, err_code};
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic clear_inputs();
        gpu_rst_done = 1'b0;
        link_active  = 1'b0;
        cause_req    = 1'b0;
    endtask

    task automatic por_pulse();
        clear_inputs();
        @(negedge clk);
        por_req = 1'b1;
        @(negedge clk);
        por_req = 1'b0;
    endtask

    // one boot attempt; fail_stage 0 = succeed, 1..3 = stage left silent
    task automatic run_attempt(input int fail_stage, input bit late, input bit last);
        int n;
        n = 0;
        while (!gpu_rst_n && n < 1000) begin @(negedge clk); n++; end
        chk(gpu_rst_n == 1'b1, "R2 gpu released", gpu_rst_n, 1);
        chk(cpu_rst_n == 1'b0, "R2 cpu still held", cpu_rst_n, 0);
        if (fail_stage == 1) begin
            push_exp(CODE_GPU_RST);
            n = 0;
            while (gpu_rst_n) begin n++; @(negedge clk); end
            chk(n == T_GPU, "R3 reset-done window", n, T_GPU);
        end else begin
            if (late) repeat (T_GPU - 1) @(negedge clk);
            gpu_rst_done = 1'b1;
            @(negedge clk);
            chk(cpu_rst_n == 1'b0 && gpu_rst_n, "R5 cpu held during link wait", cpu_rst_n, 0);
            if (fail_stage == 2) begin
                push_exp(CODE_LINK);
                n = 0;
                while (gpu_rst_n) begin n++; @(negedge clk); end
                chk(n == T_LINK, "R4 link window", n, T_LINK);
            end else begin
                if (late) repeat (T_LINK - 1) @(negedge clk);
                link_active = 1'b1;
                @(negedge clk);
                chk(cpu_rst_n == 1'b1, "R5 cpu released after link", cpu_rst_n, 1);
                if (fail_stage == 3) begin
                    push_exp(CODE_HSHAKE);
                    n = 0;
                    while (cpu_rst_n) begin n++; @(negedge clk); end
                    chk(n == T_HS, "R5 handshake window", n, T_HS);
                end else begin
                    if (late) repeat (T_HS - 1) @(negedge clk);
                    cause_req = 1'b1;
                    @(negedge clk);
                    cause_req = 1'b0;
                    chk(boot_done == 1'b1, late ? "R6 last-cycle accept" : "R9 done", boot_done, 1);
                end
            end
        end
        if (fail_stage != 0) begin
            gpu_rst_done = 1'b0;
            link_active  = 1'b0;
            if (!last) begin
                n = 0;
                while (!gpu_rst_n && n < 1000) begin
                    if (cpu_rst_n) chk(1'b0, "R7 cpu during hold", 1, 0);
                    n++;
                    @(negedge clk);
                end
                chk(n == HOLD_CYC, "R7 hold length", n, HOLD_CYC);
            end else begin
                for (int i = 0; i < 60; i++) begin
                    @(negedge clk);
                    if (gpu_rst_n || cpu_rst_n) chk(1'b0, "R8 stuck released", 1, 0);
                end
                chk({err_class, err_code} == model, "R8 stuck code", {err_class, err_code}, model);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!gpu_rst_n && !cpu_rst_n && !boot_done, "R1 outputs in reset", {gpu_rst_n, cpu_rst_n, boot_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({err_class, err_code} == 10'h000, "R1 error clear", {err_class, err_code}, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (gpu_rst_n) chk(1'b0, "R2 release without power", 1, 0);
        end
        chk(gpu_rst_n == 1'b0, "R2 idle without power", gpu_rst_n, 0);
        pwr_ok = 1'b1;

        // clean boot
        run_attempt(0, 1'b0, 1'b0);
        chk(err_class == 2'd0, "R1 no error after clean boot", err_class, 0);
        repeat (100) @(negedge clk);
        chk(boot_done && gpu_rst_n && cpu_rst_n, "R9 done sticky", boot_done, 1);

        // one failure, then success on the final cycle of every window
        por_pulse();
        run_attempt(1, 1'b0, 1'b0);
        run_attempt(0, 1'b1, 1'b0);
        chk(err_code == CODE_GPU_RST && err_class == 2'd1, "R10 code kept after success", err_code, CODE_GPU_RST);

        // five failures across stages -> stuck on the last failing stage
        por_pulse();
        run_attempt(1, 1'b0, 1'b0);
        run_attempt(1, 1'b0, 1'b0);
        run_attempt(2, 1'b0, 1'b0);
        run_attempt(3, 1'b0, 1'b0);
        run_attempt(3, 1'b0, 1'b1);
        chk(err_code == CODE_HSHAKE, "R8 final stage code", err_code, CODE_HSHAKE);

        // power-on request restores attempts
        por_pulse();
        run_attempt(2, 1'b0, 1'b0);
        chk(gpu_rst_n == 1'b1, "R11 retry after por", gpu_rst_n, 1);
        run_attempt(0, 1'b0, 1'b0);
        chk(boot_done == 1'b1, "R11 boot after por", boot_done, 1);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all expected errors seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule